// File: doc/BRIEF.md
# Multiple-Word Store Sequencer

This block carries out a store of several consecutive general registers as one multicycle operation. One start pulse supplies a starting register index, a base register field with the value of that register, and a signed 16-bit displacement. The block then walks the register indices from the starting index up to the last register (index 31). For each index it writes the low 32-bit half of that register to memory as one 4-byte write, at consecutive word addresses.

The block reads the register file through one synchronous read port: data appears on the cycle after the index is presented. It issues writes over a valid/ready handshake. Each register read is issued one cycle ahead of the write that uses it, so an always-ready memory gets one write per cycle. A stalled memory freezes the pending write in place. Busy covers the run, and a one-cycle done pulse closes it. No status or special register is changed.

Top module: `multiword_store`

## Requirements
- R1: The first write address is B + sign-extended disp. B is 0 when the base field is 0, whatever the base value input holds. Otherwise B is the base value input.
- R2: The first write carries bits [31:0] of register startReg. These are the low word, taken from the register file read data one cycle after the index is presented on rfRdAddr.
- R3: Each following write uses the next register index and an address 4 higher than the previous write.
- R4: A run makes exactly 32 - startReg writes, and its last write carries register 31.
- R5: While memValid is high and memReady is low, memValid stays high and memAddr and memData hold their values.
- R6: done is high for exactly one cycle. That cycle follows the cycle in which the register 31 write is accepted. busy is high from the cycle after the start pulse until that done cycle, and it is low while done is high.
- R7: A start pulse while busy is high is ignored. The running sequence keeps its addresses and data, and no extra writes follow its done.
- R8: With memReady held high, the first write is valid two cycles after the start cycle, and the writes follow one per cycle with no gaps.
- R9: After reset, busy, done and memValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse, taken only when idle |
| startReg | input | 5 | First register index to store |
| baseField | input | 5 | Base register field; 0 selects a zero base |
| baseValue | input | 64 | Contents of the base register |
| disp | input | 16 | Signed displacement |
| rfRdAddr | output | 5 | Register file read index |
| rfRdData | input | 64 | Register file read data, one cycle after the index |
| memValid | output | 1 | Write request valid |
| memAddr | output | 64 | Write byte address |
| memData | output | 32 | Write data word |
| memReady | input | 1 | Memory accepts the write this cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the read lookahead under mixed stall patterns. A design that re-presented the old index after an accept would write one register twice and skip the next. A base field of 0 paired with a nonzero base value catches a design that adds the register contents anyway, and a negative displacement catches a missing sign extension. A start index of 31 gives a one-word run, and a start index of 0 gives all 32 words; an off-by-one in the end test would store one word too many or too few. A second start pulse in the middle of a run would, in a design that accepts it, restart the sequence or add writes after done.

// File: rtl/mws_pkg.sv
package mws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } mwsState_t;

  typedef struct packed {
    logic idle;     // sequencer waiting for a start
    logic load;     // capture start index and effective address
    logic capture;  // capture first read data into the write register
    logic advance;  // current write accepted this cycle
  } mwsStrobes_t;
endpackage

// File: rtl/mws_ctrl.sv
module mws_ctrl
  import mws_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startValid,
  input  logic        memReady,
  input  logic        lastReg,
  output mwsStrobes_t strb,
  output logic        memValid,
  output logic        busy,
  output logic        done
);
  mwsState_t state, stateNext;
  logic doneQ;
  logic accept;

  assign accept       = (state == ST_RUN) && memReady;
  assign strb.idle    = (state == ST_IDLE);
  assign strb.load    = (state == ST_IDLE) && startValid;
  assign strb.capture = (state == ST_FETCH);
  assign strb.advance = accept;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (startValid) stateNext = ST_FETCH;
      ST_FETCH: stateNext = ST_RUN;
      ST_RUN:   if (accept && lastReg) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      doneQ <= 1'b0;
    end else begin
      state <= stateNext;
      doneQ <= accept && lastReg;
    end
  end

  assign memValid = (state == ST_RUN);
  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;

  // R6: done lasts one cycle only
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R6: busy and done never overlap
  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R4: accepting the last register ends the run with done
  p_last_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memReady && lastReg) |=> (done && !memValid));
  // R8: first write follows the fetch cycle directly
  p_first_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> memValid);
endmodule

// File: rtl/mws_dp.sv
module mws_dp
  import mws_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int ADDR_W   = 64,
  parameter int WORD_W   = 32,
  parameter int DISP_W   = 16,
  parameter int NUM_REGS = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mwsStrobes_t                 strb,
  input  logic [$clog2(NUM_REGS)-1:0] startReg,
  input  logic [$clog2(NUM_REGS)-1:0] baseField,
  input  logic [XLEN-1:0]             baseValue,
  input  logic [DISP_W-1:0]           disp,
  input  logic [XLEN-1:0]             rfRdData,
  output logic [$clog2(NUM_REGS)-1:0] rfRdAddr,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [WORD_W-1:0]           memData,
  output logic                        lastReg
);
  localparam int IDX_W = $clog2(NUM_REGS);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_REGS - 1);
  localparam logic [IDX_W-1:0]  IDX_ONE  = IDX_W'(1);
  localparam logic [IDX_W-1:0]  IDX_TWO  = IDX_W'(2);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_W / 8);

  logic [IDX_W-1:0]  curReg;
  logic [ADDR_W-1:0] addrQ;
  logic [WORD_W-1:0] wrData;
  logic [ADDR_W-1:0] baseEff;
  logic [ADDR_W-1:0] dispExt;
  logic [ADDR_W-1:0] effAddr;
  logic              unusedHigh;

  assign unusedHigh = ^rfRdData[XLEN-1:WORD_W];

  generate
    if (XLEN >= ADDR_W) begin : g_base_trim
      assign baseEff = (baseField == '0) ? '0 : baseValue[ADDR_W-1:0];
    end else begin : g_base_pad
      assign baseEff = (baseField == '0) ? '0 : {{(ADDR_W-XLEN){1'b0}}, baseValue};
    end
  endgenerate

  assign dispExt = {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
  assign effAddr = baseEff + dispExt;
  assign lastReg = (curReg == LAST_IDX);

  // Lookahead: the read issued now must be the one needed after the next accept.
  always_comb begin
    if (strb.idle)         rfRdAddr = startReg;
    else if (strb.advance) rfRdAddr = curReg + IDX_TWO;
    else                   rfRdAddr = curReg + IDX_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curReg <= '0;
      addrQ  <= '0;
      wrData <= '0;
    end else begin
      if (strb.load) begin
        curReg <= startReg;
        addrQ  <= effAddr;
      end
      if (strb.capture) wrData <= rfRdData[WORD_W-1:0];
      if (strb.advance && !lastReg) begin
        curReg <= curReg + IDX_ONE;
        addrQ  <= addrQ + STEP;
        wrData <= rfRdData[WORD_W-1:0];
      end
    end
  end

  assign memAddr = addrQ;
  assign memData = wrData;

  // R3: an accepted non-final write moves to the next register index
  p_reg_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !lastReg) |=> (curReg == $past(curReg) + IDX_ONE));
  // R3: and the address moves by one word
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !lastReg) |=> (memAddr == $past(memAddr) + STEP));
endmodule

// File: rtl/multiword_store.sv
module multiword_store
  import mws_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int ADDR_W   = 64,
  parameter int WORD_W   = 32,
  parameter int DISP_W   = 16,
  parameter int NUM_REGS = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        startValid,
  input  logic [$clog2(NUM_REGS)-1:0] startReg,
  input  logic [$clog2(NUM_REGS)-1:0] baseField,
  input  logic [XLEN-1:0]             baseValue,
  input  logic [DISP_W-1:0]           disp,
  output logic [$clog2(NUM_REGS)-1:0] rfRdAddr,
  input  logic [XLEN-1:0]             rfRdData,
  output logic                        memValid,
  output logic [ADDR_W-1:0]           memAddr,
  output logic [WORD_W-1:0]           memData,
  input  logic                        memReady,
  output logic                        busy,
  output logic                        done
);
  mwsStrobes_t strb;
  logic lastReg;

  mws_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .memReady(memReady),
    .lastReg(lastReg), .strb(strb), .memValid(memValid), .busy(busy), .done(done)
  );

  mws_dp #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .DISP_W(DISP_W), .NUM_REGS(NUM_REGS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .startReg(startReg), .baseField(baseField),
    .baseValue(baseValue), .disp(disp), .rfRdData(rfRdData), .rfRdAddr(rfRdAddr),
    .memAddr(memAddr), .memData(memData), .lastReg(lastReg)
  );

  // R5: a stalled write is held unchanged
  p_hold_stall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && !memReady) |=> (memValid && $stable(memAddr) && $stable(memData)));
endmodule

// File: tb/tb_multiword_store.sv
module tb_multiword_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [4:0]  startReg = '0;
  logic [4:0]  baseField = '0;
  logic [63:0] baseValue = '0;
  logic [15:0] disp = '0;
  logic [4:0]  rfRdAddr;
  logic [63:0] rfRdData = '0;
  logic        memValid;
  logic [63:0] memAddr;
  logic [31:0] memData;
  logic        memReady = 1'b0;
  logic        busy;
  logic        done;

  always #4 clk = ~clk;

  multiword_store dut (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startReg(startReg),
    .baseField(baseField), .baseValue(baseValue), .disp(disp), .rfRdAddr(rfRdAddr),
    .rfRdData(rfRdData), .memValid(memValid), .memAddr(memAddr), .memData(memData),
    .memReady(memReady), .busy(busy), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int readyMode = 0;

  logic [63:0] regs [32];
  always @(posedge clk) rfRdData <= regs[rfRdAddr];
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] logAddr [64];
  logic [31:0] logData [64];
  int          logCyc  [64];
  int          logCount = 0;
  int          doneCount = 0;
  int          doneCyc = -1;
  int          overlap = 0;
  int          stallErr = 0;
  int          stallSeen = 0;
  logic        pending = 1'b0;
  logic [63:0] heldAddr = '0;
  logic [31:0] heldData = '0;

  always @(negedge clk) begin
    logic r;
    case (readyMode)
      0:       r = 1'b1;
      1:       r = cyc[0];
      default: r = ((cyc % 3) == 2);
    endcase
    memReady = r;
    if (pending && (!memValid || memAddr != heldAddr || memData != heldData)) stallErr++;
    pending = 1'b0;
    if (memValid) begin
      if (r) begin
        if (logCount < 64) begin
          logAddr[logCount] = memAddr;
          logData[logCount] = memData;
          logCyc[logCount]  = cyc;
        end
        logCount++;
      end else begin
        pending = 1'b1; heldAddr = memAddr; heldData = memData; stallSeen++;
      end
    end
    if (done) begin
      doneCount++;
      if (doneCyc < 0) doneCyc = cyc;
      if (busy) overlap++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logCount = 0; doneCount = 0; doneCyc = -1; overlap = 0; stallErr = 0; stallSeen = 0;
  endtask

  // One sequence with its own checks; reStart pulses start again mid-run (R7).
  task automatic runSeq(input int s, input int bf, input logic [63:0] bv,
                        input logic [15:0] d, input int mode, input bit reStart);
    logic [63:0] base, ea;
    int n, startCyc, saved;
    base = (bf == 0) ? 64'd0 : bv;
    ea = base + {{48{d[15]}}, d};
    n = 32 - s;
    readyMode = mode;
    @(negedge clk);
    clearLog();
    startReg = 5'(s); baseField = 5'(bf); baseValue = bv; disp = d;
    startValid = 1'b1; startCyc = cyc;
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 1'b1, "R6 busy after start", 64'(busy), 64'd1);
    if (reStart) begin
      @(negedge clk);
      startReg = 5'd3; baseField = 5'd7; baseValue = 64'h9999_0000; disp = 16'h0100;
      startValid = 1'b1;
      repeat (2) @(negedge clk);
      startValid = 1'b0;
    end
    for (int t = 0; t < 400 && doneCyc < 0; t++) @(negedge clk);
    check(doneCyc >= 0, "R6 done seen", 64'(doneCyc), 64'd0);
    saved = logCount;
    repeat (6) @(negedge clk);
    check(logCount == n, "R4 write count", 64'(logCount), 64'(n));
    check(logCount == saved, "R7 no writes after done", 64'(logCount), 64'(saved));
    check(logCount > 0 && logAddr[0] == ea, "R1 first address", logAddr[0], ea);
    check(logCount > 0 && logData[0] == regs[s][31:0], "R2 first data", 64'(logData[0]), 64'(regs[s][31:0]));
    for (int k = 1; k < n && k < logCount; k++) begin
      check(logAddr[k] == ea + 64'(4 * k), "R3 address step", logAddr[k], ea + 64'(4 * k));
      check(logData[k] == regs[s + k][31:0], "R3 data order", 64'(logData[k]), 64'(regs[s + k][31:0]));
    end
    if (logCount > 0)
      check(logData[logCount - 1] == regs[31][31:0], "R4 last is register 31",
            64'(logData[logCount - 1]), 64'(regs[31][31:0]));
    if (logCount > 0)
      check(doneCyc == logCyc[logCount - 1] + 1, "R6 done timing", 64'(doneCyc), 64'(logCyc[logCount - 1] + 1));
    check(doneCount == 1, "R6 done width", 64'(doneCount), 64'd1);
    check(overlap == 0, "R6 busy low with done", 64'(overlap), 64'd0);
    check(busy == 1'b0 && memValid == 1'b0, "R7 idle after done", 64'({busy, memValid}), 64'd0);
    check(stallErr == 0, "R5 stall hold", 64'(stallErr), 64'd0);
    if (mode != 0) check(stallSeen > 0, "R5 stalls exercised", 64'(stallSeen), 64'd1);
    if (mode == 0 && logCount > 0) begin
      check(logCyc[0] == startCyc + 2, "R8 first write latency", 64'(logCyc[0]), 64'(startCyc + 2));
      check(logCyc[logCount - 1] - logCyc[0] == logCount - 1, "R8 back-to-back",
            64'(logCyc[logCount - 1] - logCyc[0]), 64'(logCount - 1));
    end
  endtask

  initial begin
    #(8 * 150000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++)
      regs[i] = {32'hDEAD_0000 + 32'(i), 32'h5A00_0000 + 32'(i) * 32'h0001_0203};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b0, "R9 busy after reset", 64'(busy), 64'd0);
    check(done == 1'b0, "R9 done after reset", 64'(done), 64'd0);
    check(memValid == 1'b0, "R9 memValid after reset", 64'(memValid), 64'd0);
    // R1 zero base with nonzero value, R8 always ready
    runSeq(29, 0, 64'hFFFF_0000_1234_0000, 16'h0040, 0, 1'b0);
    // R4 single-word run from register 31
    runSeq(31, 4, 64'h0000_0000_8000_0000, 16'h0008, 0, 1'b0);
    // R4 full run from register 0, R5 alternating stalls
    runSeq(0, 12, 64'h0000_0001_0000_1000, 16'h0010, 1, 1'b0);
    // R1 negative displacement, R5 sparse ready
    runSeq(20, 9, 64'h0000_0000_0002_0000, 16'hFF00, 2, 1'b0);
    // R7 start during a busy run
    runSeq(10, 2, 64'h0000_0000_0040_0000, 16'h0020, 1, 1'b1);
    // R8 back-to-back with a negative offset from the zero base
    runSeq(16, 0, 64'h1111_2222_3333_4444, 16'h8000, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule